// File: doc/BRIEF.md
# Pinned-Write Wakeup Scoreboard

This block tracks whether each physical register can be read by instructions that wait to issue. When rename gives a destination a fresh physical register, it also gives a pin count: the number of extra writes that register will take before its value is final. The block loads a countdown with that count plus one and marks the register not ready. Each writeback for the register takes one off the countdown. Only the writeback that brings the countdown to exactly zero marks the register ready and raises a wakeup for its tag. A register with a pin count of zero therefore becomes ready on its first writeback.

Several writeback ports work in parallel, and writes that hit one register in the same cycle are added together. Each register keeps a one-bit generation that flips on every fresh allocation. Each writeback carries the generation it was renamed under, so a late writeback to an earlier life of the register is ignored. A rename that reuses the current mapping (a later pinned write to the same register) only clears the ready bit. Each port also reports whether its write landed on a pinned register, and a write that would take the countdown below zero is flagged as an error.

Top module: `pin_wake_sb`

## Requirements
- R1: After reset, every ready bit is 1, every register's generation is 0, no wakeup is raised and `wb_err` is 0.
- R2: A rename with `ren_alloc`=1 and pin count P makes that register not ready from the next cycle, loads its countdown with P+1, flips its generation and records it as pinned when P is nonzero.
- R3: A rename with `ren_alloc`=0 clears the register's ready bit from the next cycle and leaves its countdown and generation unchanged.
- R4: A writeback whose generation bit differs from the register's current generation is stale: it raises no wakeup, no pin flag and no error, and it does not change the register.
- R5: Each valid writeback with a matching generation takes one off its register's countdown, and writes to one register in the same cycle are summed.
- R6: `wake_valid[i]` is 1 in the same cycle as port i's writeback exactly when that cycle's summed writes bring the register's countdown to exactly zero. Otherwise it is 0.
- R7: When a register's countdown reaches zero, its ready bit is 1 from the next cycle.
- R8: `pin_written[i]` is 1 in the same cycle as a generation-matching writeback on port i to a register whose last fresh allocation had a nonzero pin count.
- R9: Writes that exceed the remaining countdown raise `wb_err` in the same cycle and raise no wakeup for that register. The countdown is left at zero and the ready bit is unchanged.
- R10: When a rename with `ren_alloc`=0 and writebacks hit one register in the same cycle, a generation-matching writeback that completes the countdown leaves the register ready. Otherwise the rename wins and the register is not ready.
- R11: When a rename with `ren_alloc`=1 and writebacks hit one register in the same cycle, the wakeup and pin outputs are judged on the register's state before the allocation. The register's next state is exactly what the allocation sets.
- R12: Writeback port i carries its tag in bits [i*TW +: TW] of `wb_tag`, and `wake_tag` uses the same layout, where TW is the tag width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | Rename request for `ren_tag` |
| ren_alloc | input | 1 | 1: fresh allocation; 0: reuse of the current mapping |
| ren_tag | input | TW | Physical register named by the rename |
| ren_pins | input | PW | Pin count for a fresh allocation |
| wb_valid | input | NWB | Writeback valid, one bit per port |
| wb_tag | input | NWB*TW | Writeback tags, packed per port |
| wb_gen | input | NWB | Generation bit of each writeback |
| ready | output | NREG | Ready bit per physical register |
| wake_valid | output | NWB | Wakeup broadcast per port |
| wake_tag | output | NWB*TW | Tag broadcast with each wakeup |
| pin_written | output | NWB | Port wrote a pinned register |
| wb_err | output | 1 | Countdown would go below zero |

## Verification
A countdown that is wrong by one shows up at the ports on the writeback where the register should have completed. That cycle's wakeup is missing or comes one write early, and the ready bit is wrong on the edge that follows. A wrong generation shows up on the very next writeback to that register: a valid write goes silent, or a stale write raises a wakeup or an error. A lost pinned flag clears `pin_written` on the first matching write. Each scenario therefore drives the exact number of writes and checks the same-cycle outputs and the ready bit one edge later.

// File: rtl/pin_wake_sb.sv
`timescale 1ns/1ps
module pin_wake_sb #(
  parameter int NREG    = 16,
  parameter int NWB     = 2,
  parameter int PIN_MAX = 3,
  localparam int TW = $clog2(NREG),
  localparam int PW = $clog2(PIN_MAX + 1),
  localparam int CW = $clog2(PIN_MAX + 2),
  localparam int DW = $clog2(NWB + 1),
  localparam int XW = ((CW > DW) ? CW : DW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic              ren_alloc,
  input  logic [TW-1:0]     ren_tag,
  input  logic [PW-1:0]     ren_pins,
  input  logic [NWB-1:0]    wb_valid,
  input  logic [NWB*TW-1:0] wb_tag,
  input  logic [NWB-1:0]    wb_gen,
  output logic [NREG-1:0]   ready,
  output logic [NWB-1:0]    wake_valid,
  output logic [NWB*TW-1:0] wake_tag,
  output logic [NWB-1:0]    pin_written,
  output logic              wb_err
);

  logic [CW-1:0]   cnt_q [NREG];
  logic [CW-1:0]   cnt_d [NREG];
  logic [DW-1:0]   dec   [NREG];
  logic [NREG-1:0] gen_q, pin_q, rdy_q, under, done;
  logic [TW-1:0]   tag_p [NWB];
  logic [NWB-1:0]  live;

  always_comb begin
    for (int i = 0; i < NWB; i++) begin
      tag_p[i] = wb_tag[i*TW +: TW];
      live[i]  = wb_valid[i] && (wb_gen[i] == gen_q[tag_p[i]]);
    end
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      dec[r] = '0;
      for (int i = 0; i < NWB; i++)
        if (live[i] && tag_p[i] == TW'(r)) dec[r] = dec[r] + DW'(1);
      under[r] = XW'(dec[r]) > XW'(cnt_q[r]);
      done[r]  = (dec[r] != '0) && (XW'(dec[r]) == XW'(cnt_q[r]));
      cnt_d[r] = under[r] ? '0 : CW'(XW'(cnt_q[r]) - XW'(dec[r]));
    end
  end

  always_comb begin
    for (int i = 0; i < NWB; i++) begin
      wake_valid[i]  = live[i] && done[tag_p[i]];
      pin_written[i] = live[i] && pin_q[tag_p[i]];
    end
  end

  assign wake_tag = wb_tag;
  assign wb_err   = |under;
  assign ready    = rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) cnt_q[r] <= '0;
      gen_q <= '0;
      pin_q <= '0;
      rdy_q <= '1;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (ren_valid && ren_tag == TW'(r) && ren_alloc) begin
          cnt_q[r] <= CW'(ren_pins) + CW'(1);
          gen_q[r] <= ~gen_q[r];
          pin_q[r] <= |ren_pins;
          rdy_q[r] <= 1'b0;
        end else begin
          if (dec[r] != '0) cnt_q[r] <= cnt_d[r];
          if (done[r]) rdy_q[r] <= 1'b1;
          else if (ren_valid && ren_tag == TW'(r)) rdy_q[r] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pin_wake_sb_chk.sv
`timescale 1ns/1ps
module pin_wake_sb_chk #(
  parameter int NREG    = 16,
  parameter int NWB     = 2,
  parameter int PIN_MAX = 3,
  localparam int TW = $clog2(NREG),
  localparam int PW = $clog2(PIN_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ren_valid,
  input logic              ren_alloc,
  input logic [TW-1:0]     ren_tag,
  input logic [PW-1:0]     ren_pins,
  input logic [NWB-1:0]    wb_valid,
  input logic [NWB*TW-1:0] wb_tag,
  input logic [NWB-1:0]    wb_gen,
  input logic [NREG-1:0]   ready,
  input logic [NWB-1:0]    wake_valid,
  input logic [NWB-1:0]    pin_written,
  input logic              wb_err
);

  logic [NREG-1:0] wb_hit, ren_hit;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      wb_hit[r]  = 1'b0;
      for (int i = 0; i < NWB; i++)
        if (wb_valid[i] && wb_tag[i*TW +: TW] == TW'(r)) wb_hit[r] = 1'b1;
      ren_hit[r] = ren_valid && ren_tag == TW'(r);
    end
  end

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && ren_alloc |=> !ready[$past(ren_tag)]); // R2

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    AST_RISE_NEEDS_WB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready[r]) |-> $past(wb_hit[r])); // R7
    AST_FALL_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready[r]) |-> $past(ren_hit[r])); // R3
  end

  for (genvar i = 0; i < NWB; i++) begin : g_port
    AST_WAKE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid[i] && !(ren_valid && ren_tag == wb_tag[i*TW +: TW])
      |=> ready[$past(wb_tag[i*TW +: TW])]); // R7
    AST_PIN_NEEDS_WB: assert property (@(posedge clk) disable iff (!rst_n)
      pin_written[i] |-> wb_valid[i]); // R8
  end

endmodule

bind pin_wake_sb pin_wake_sb_chk #(.NREG(NREG), .NWB(NWB), .PIN_MAX(PIN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_alloc(ren_alloc),
  .ren_tag(ren_tag), .ren_pins(ren_pins), .wb_valid(wb_valid), .wb_tag(wb_tag),
  .wb_gen(wb_gen), .ready(ready), .wake_valid(wake_valid),
  .pin_written(pin_written), .wb_err(wb_err)
);

// File: tb/test_pin_wake_sb.sv
`timescale 1ns/1ps
module test_pin_wake_sb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16, NWB = 2, PIN_MAX = 3;
  localparam int TW = $clog2(NREG), PW = $clog2(PIN_MAX + 1);

  logic clk = 0, rst_n = 0;
  logic ren_valid, ren_alloc;
  logic [TW-1:0] ren_tag;
  logic [PW-1:0] ren_pins;
  logic [NWB-1:0] wb_valid, wb_gen, wake_valid, pin_written;
  logic [NWB*TW-1:0] wb_tag, wake_tag;
  logic [NREG-1:0] ready;
  logic wb_err;
  int checks = 0, errors = 0;
  bit finished = 0;

  pin_wake_sb #(.NREG(NREG), .NWB(NWB), .PIN_MAX(PIN_MAX)) i_pin_wake_sb (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_alloc(ren_alloc),
    .ren_tag(ren_tag), .ren_pins(ren_pins), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_gen(wb_gen), .ready(ready), .wake_valid(wake_valid), .wake_tag(wake_tag),
    .pin_written(pin_written), .wb_err(wb_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    ren_valid = 0; ren_alloc = 0; ren_tag = '0; ren_pins = '0;
    wb_valid = '0; wb_tag = '0; wb_gen = '0;
  endtask

  task automatic ren(int tag, bit alloc, int pins);
    ren_valid = 1; ren_alloc = alloc; ren_tag = TW'(tag); ren_pins = PW'(pins);
  endtask

  task automatic wb(int port, int tag, bit gen);
    wb_valid[port] = 1; wb_tag[port*TW +: TW] = TW'(tag); wb_gen[port] = gen;
  endtask

  task automatic settle(); #1; endtask

  task automatic step();
    @(posedge clk); @(negedge clk); clear_in(); #1;
  endtask

  task automatic t_reset();
    chk("R1 ready", ready, 16'hFFFF);
    chk("R1 wake", wake_valid, 0);
    chk("R1 err", wb_err, 0);
  endtask

  task automatic t_unpinned();
    ren(3, 1, 0); step();
    chk("R2 alloc clears", ready[3], 0);
    wb(0, 3, 1); settle();
    chk("R6 wake on first write", wake_valid[0], 1);
    chk("R12 wake tag port0", wake_tag[0 +: TW], 3);
    chk("R8 unpinned no flag", pin_written[0], 0);
    step();
    chk("R7 ready after wake", ready[3], 1);
  endtask

  task automatic t_pinned();
    ren(5, 1, 2); step();
    wb(0, 5, 1); settle();
    chk("R6 pinned first no wake", wake_valid[0], 0);
    chk("R8 pinned flag", pin_written[0], 1);
    step();
    chk("R6 still not ready", ready[5], 0);
    ren(5, 0, 0); step();
    chk("R3 reuse keeps not ready", ready[5], 0);
    wb(1, 5, 1); settle();
    chk("R6 pinned second no wake", wake_valid[1], 0);
    step();
    wb(0, 5, 1); settle();
    chk("R3 counter kept, third write wakes", wake_valid[0], 1);
    step();
    chk("R7 pinned ready", ready[5], 1);
  endtask

  task automatic t_multi();
    ren(7, 1, 1); step();
    wb(0, 7, 1); wb(1, 7, 1); settle();
    chk("R5 summed writes wake both", wake_valid, 2'b11);
    chk("R5 no err", wb_err, 0);
    chk("R12 wake tag port1", wake_tag[TW +: TW], 7);
    step();
    chk("R7 ready after summed", ready[7], 1);
  endtask

  task automatic t_underflow();
    wb(0, 3, 1); settle();
    chk("R9 err on zero count", wb_err, 1);
    chk("R9 no wake", wake_valid[0], 0);
    step();
    chk("R9 ready unchanged", ready[3], 1);
    ren(8, 1, 0); step();
    wb(0, 8, 1); wb(1, 8, 1); settle();
    chk("R9 err on excess sum", wb_err, 1);
    chk("R9 no wake on excess", wake_valid, 0);
    step();
    chk("R9 stays not ready", ready[8], 0);
    wb(0, 8, 1); settle();
    chk("R9 count left at zero", wb_err, 1);
    step();
  endtask

  task automatic t_stale();
    ren(9, 1, 0); step();
    wb(0, 9, 0); settle();
    chk("R4 stale no wake", wake_valid[0], 0);
    chk("R4 stale no err", wb_err, 0);
    chk("R4 stale no flag", pin_written[0], 0);
    step();
    chk("R4 stale ready unchanged", ready[9], 0);
    wb(0, 9, 1); settle();
    chk("R4 count untouched", wake_valid[0], 1);
    step();
  endtask

  task automatic t_conflict();
    ren(10, 1, 1); step();
    wb(0, 10, 1); step();
    ren(10, 0, 0); wb(0, 10, 1); settle();
    chk("R10 completing write wakes", wake_valid[0], 1);
    step();
    chk("R10 writeback wins", ready[10], 1);
    ren(11, 1, 0); step();
    wb(0, 11, 1); step();
    chk("R7 reg11 ready", ready[11], 1);
    ren(11, 0, 0); wb(0, 11, 0); step();
    chk("R10 rename wins over stale", ready[11], 0);
  endtask

  task automatic t_alloc_same();
    ren(12, 1, 0); step();
    ren(12, 1, 1); wb(0, 12, 1); settle();
    chk("R11 outputs from old state", wake_valid[0], 1);
    step();
    chk("R11 alloc leaves not ready", ready[12], 0);
    wb(0, 12, 0); settle();
    chk("R11 new gen first write no wake", wake_valid[0], 0);
    chk("R11 new pinned flag", pin_written[0], 1);
    step();
    wb(0, 12, 0); settle();
    chk("R11 second write wakes", wake_valid[0], 1);
    step();
    chk("R7 reg12 ready", ready[12], 1);
  endtask

  initial begin
    clear_in();
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_unpinned();
    t_pinned();
    t_multi();
    t_underflow();
    t_stale();
    t_conflict();
    t_alloc_same();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule